// File: doc/BRIEF.md
# Even/Odd Byte-Bank Memory Port

This block sits between a 16-bit processor data port and a byte-wide memory that is split into two banks. One bank holds every even byte address and carries the low data lane. The other holds every odd byte address and carries the high data lane. A request asks for a byte or a 16-bit word at any byte address, either to read or to write. The block decides which banks take part and which row of each bank is used. It moves each byte to the correct lane, and it reports completion with a one-cycle done pulse.

A word that starts on an even address touches both banks in one bank cycle. A word that starts on an odd address straddles a row boundary, so the block splits it into two bank cycles. The first cycle handles the odd bank, and the second handles the next even row. In both cases the word is stored least-significant byte first. Read results are always right-justified. Both banks are synchronous byte arrays inside the block, and the bank strobes and rows are brought out so that each bank cycle can be observed.

Top module: `dual_bank_mem_if`

## Requirements
- R1: After reset, busy, done, rd_data and all four bank strobes are low until a request is accepted.
- R2: A request with req_valid high while busy is low is accepted at that clock edge. busy is high from the next cycle up to and including the single cycle in which done is high, and busy is low in the cycle after done.
- R3: A request presented while busy is high is dropped. It changes no memory byte and does not start a further access after the current one.
- R4: A word access at an even address uses one bank cycle with both banks enabled at row addr>>1. done is high in the second cycle after acceptance.
- R5: Words are little endian. A word written at address A puts bits 7:0 at byte A and bits 15:8 at byte A+1, and a word read at A returns byte A in bits 7:0.
- R6: A byte access at an even address enables only the even bank. A write stores req_wdata[7:0], and a read returns the byte in rd_data[7:0] with rd_data[15:8] zero.
- R7: A byte access at an odd address enables only the odd bank. A write stores req_wdata[15:8], and a read returns the byte in rd_data[7:0] with rd_data[15:8] zero.
- R8: A word access at an odd address A uses two bank cycles. The first enables only the odd bank at row A>>1 and carries the low byte. The second enables only the even bank at row (A+1)>>1 and carries the high byte. done is high in the third cycle after acceptance.
- R9: A bank write enable is high only in a write cycle and only for a bank that is enabled in that cycle. Reads assert no write enable.
- R10: A word at the highest odd address wraps, so its high byte lands at byte address 0 (even row 0).
- R11: rd_data is zero in every cycle except the done cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data (byte writes take the lane given by address bit 0) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Right-justified read result, valid with done |
| bank_even_en | output | 1 | Even bank enable |
| bank_odd_en | output | 1 | Odd bank enable |
| bank_even_we | output | 1 | Even bank write enable |
| bank_odd_we | output | 1 | Odd bank write enable |
| bank_even_row | output | ADDR_W-1 | Even bank row |
| bank_odd_row | output | ADDR_W-1 | Odd bank row |

## Verification
A sequencer stuck in the wrong phase shows up within one or two cycles as a missing or duplicated done pulse, or as a bank strobe firing outside busy. A wrong lane choice or row computation lands a byte at the wrong address. That error stays hidden until the byte is read back, so every write in the test is followed by byte and word reads of the same and neighbouring addresses. The two cycles of a split word expose row arithmetic errors directly on the bank row outputs, including the wrap to row zero.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    // Sequencer phases of one access
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BANK1 = 2'd1,
        PH_BANK2 = 2'd2,
        PH_RESP  = 2'd3
    } phase_e;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;

endpackage

// File: rtl/dbm_bank.sv
module dbm_bank #(
    parameter int ROW_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     we,
    input  logic [ROW_W-1:0]         row,
    input  logic [dbm_pkg::BYTE_W-1:0] wdata,
    output logic [dbm_pkg::BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ROW_W;

    logic [dbm_pkg::BYTE_W-1:0] mem [DEPTH];
    logic [dbm_pkg::BYTE_W-1:0] rdata_d, rdata_q;

    // Output register only moves on a read; it holds otherwise
    always_comb begin
        rdata_d = rdata_q;
        if (en && !we) begin
            rdata_d = mem[row];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[row] <= wdata;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dbm_ctrl.sv
module dbm_ctrl #(
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_word,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [dbm_pkg::WORD_W-1:0] req_wdata,
    output dbm_pkg::phase_e           phase,
    output logic                      op_write,
    output logic                      op_word,
    output logic [ADDR_W-1:0]         op_addr,
    output logic [dbm_pkg::WORD_W-1:0] op_wdata
);
    import dbm_pkg::*;

    typedef struct packed {
        phase_e              ph;
        logic                wr;
        logic                wd;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   wdata;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  split;

    assign split = s_q.wd && s_q.addr[0];

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph    = PH_BANK1;
                    s_d.wr    = req_write;
                    s_d.wd    = req_word;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                end
            end
            PH_BANK1: s_d.ph = split ? PH_BANK2 : PH_RESP;
            PH_BANK2: s_d.ph = PH_RESP;
            PH_RESP:  s_d.ph = PH_IDLE;
            default:  s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, wr: 1'b0, wd: 1'b0, addr: '0, wdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase    = s_q.ph;
    assign op_write = s_q.wr;
    assign op_word  = s_q.wd;
    assign op_addr  = s_q.addr;
    assign op_wdata = s_q.wdata;

endmodule

// File: rtl/dbm_steer.sv
module dbm_steer #(
    parameter int ADDR_W = 8
) (
    input  dbm_pkg::phase_e           phase,
    input  logic                      op_write,
    input  logic                      op_word,
    input  logic [ADDR_W-1:0]         op_addr,
    input  logic [dbm_pkg::WORD_W-1:0] op_wdata,
    input  logic [dbm_pkg::BYTE_W-1:0] even_rdata,
    input  logic [dbm_pkg::BYTE_W-1:0] odd_rdata,
    output logic                      even_en,
    output logic                      odd_en,
    output logic                      even_we,
    output logic                      odd_we,
    output logic [ADDR_W-2:0]         even_row,
    output logic [ADDR_W-2:0]         odd_row,
    output logic [dbm_pkg::BYTE_W-1:0] even_wdata,
    output logic [dbm_pkg::BYTE_W-1:0] odd_wdata,
    output logic [dbm_pkg::WORD_W-1:0] rd_data
);
    import dbm_pkg::*;

    localparam int ROW_W = ADDR_W - 1;

    logic [BYTE_W-1:0] lo_byte, hi_byte;
    logic [ADDR_W-1:0] next_addr;
    logic [ROW_W-1:0]  base_row, next_row;
    logic              odd_start;

    assign lo_byte   = op_wdata[BYTE_W-1:0];
    assign hi_byte   = op_wdata[WORD_W-1:BYTE_W];
    assign odd_start = op_addr[0];
    assign next_addr = op_addr + ADDR_W'(1);
    assign base_row  = op_addr[ADDR_W-1:1];
    assign next_row  = next_addr[ADDR_W-1:1];

    // Bank strobes, rows and lane routing per phase
    always_comb begin
        even_en    = 1'b0;
        odd_en     = 1'b0;
        even_row   = base_row;
        odd_row    = base_row;
        even_wdata = lo_byte;
        odd_wdata  = hi_byte;
        unique case (phase)
            PH_BANK1: begin
                if (op_word && !odd_start) begin
                    even_en = 1'b1;
                    odd_en  = 1'b1;
                end else if (op_word) begin
                    odd_en    = 1'b1;
                    odd_wdata = lo_byte;
                end else if (odd_start) begin
                    odd_en = 1'b1;
                end else begin
                    even_en = 1'b1;
                end
            end
            PH_BANK2: begin
                even_en    = 1'b1;
                even_row   = next_row;
                even_wdata = hi_byte;
            end
            default: ;
        endcase
        even_we = even_en && op_write;
        odd_we  = odd_en && op_write;
    end

    // Read assembly: the odd bank output register still holds the low
    // byte of a split word because that bank idles in the second cycle
    always_comb begin
        rd_data = '0;
        if (phase == PH_RESP && !op_write) begin
            if (op_word && odd_start) begin
                rd_data = {even_rdata, odd_rdata};
            end else if (op_word) begin
                rd_data = {odd_rdata, even_rdata};
            end else if (odd_start) begin
                rd_data = {{BYTE_W{1'b0}}, odd_rdata};
            end else begin
                rd_data = {{BYTE_W{1'b0}}, even_rdata};
            end
        end
    end

endmodule

// File: rtl/dual_bank_mem_if.sv
module dual_bank_mem_if #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic              bank_even_en,
    output logic              bank_odd_en,
    output logic              bank_even_we,
    output logic              bank_odd_we,
    output logic [ADDR_W-2:0] bank_even_row,
    output logic [ADDR_W-2:0] bank_odd_row
);
    import dbm_pkg::*;

    localparam int ROW_W = ADDR_W - 1;

    phase_e            phase;
    logic              op_write, op_word;
    logic [ADDR_W-1:0] op_addr;
    logic [WORD_W-1:0] op_wdata;

    logic [LANES-1:0]  lane_en, lane_we;
    logic [ROW_W-1:0]  lane_row   [LANES];
    logic [BYTE_W-1:0] lane_wdata [LANES];
    logic [BYTE_W-1:0] lane_rdata [LANES];

    dbm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase     (phase),
        .op_write  (op_write),
        .op_word   (op_word),
        .op_addr   (op_addr),
        .op_wdata  (op_wdata)
    );

    dbm_steer #(.ADDR_W(ADDR_W)) u_steer (
        .phase      (phase),
        .op_write   (op_write),
        .op_word    (op_word),
        .op_addr    (op_addr),
        .op_wdata   (op_wdata),
        .even_rdata (lane_rdata[0]),
        .odd_rdata  (lane_rdata[1]),
        .even_en    (lane_en[0]),
        .odd_en     (lane_en[1]),
        .even_we    (lane_we[0]),
        .odd_we     (lane_we[1]),
        .even_row   (lane_row[0]),
        .odd_row    (lane_row[1]),
        .even_wdata (lane_wdata[0]),
        .odd_wdata  (lane_wdata[1]),
        .rd_data    (rd_data)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        dbm_bank #(.ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (lane_en[g]),
            .we    (lane_we[g]),
            .row   (lane_row[g]),
            .wdata (lane_wdata[g]),
            .rdata (lane_rdata[g])
        );
    end

    assign busy          = (phase != PH_IDLE);
    assign done          = (phase == PH_RESP);
    assign bank_even_en  = lane_en[0];
    assign bank_odd_en   = lane_en[1];
    assign bank_even_we  = lane_we[0];
    assign bank_odd_we   = lane_we[1];
    assign bank_even_row = lane_row[0];
    assign bank_odd_row  = lane_row[1];

endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              bank_even_en,
    input logic              bank_odd_en,
    input logic              bank_even_we,
    input logic              bank_odd_we,
    input logic [ADDR_W-2:0] bank_even_row,
    input logic [ADDR_W-2:0] bank_odd_row
);
    localparam int ROW_W = ADDR_W - 1;

    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_start_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_strobe_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_even_en || bank_odd_en) |-> (busy && !done));

    assert_even_we_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_even_we |-> bank_even_en);

    assert_odd_we_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_odd_we |-> bank_odd_en);

    assert_aligned_rows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_even_en && bank_odd_en) |-> (bank_even_row == bank_odd_row));

    assert_split_next_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_even_en && !bank_odd_en && $past(bank_odd_en && !bank_even_en))
        |-> (bank_even_row == ROW_W'($past(bank_odd_row) + ROW_W'(1))));

endmodule

bind dual_bank_mem_if dbm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .busy          (busy),
    .done          (done),
    .bank_even_en  (bank_even_en),
    .bank_odd_en   (bank_odd_en),
    .bank_even_we  (bank_even_we),
    .bank_odd_we   (bank_odd_we),
    .bank_even_row (bank_even_row),
    .bank_odd_row  (bank_odd_row)
);

// File: tb/dual_bank_mem_if_tb.sv
`timescale 1ns/1ps
module dual_bank_mem_if_tb;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic          busy, done;
    logic [15:0]   rd_data;
    logic          bank_even_en, bank_odd_en, bank_even_we, bank_odd_we;
    logic [AW-2:0] bank_even_row, bank_odd_row;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dual_bank_mem_if #(.ADDR_W(AW)) u_dut (.*);

    // Per-cycle log of the bank side during one access
    logic          lg_ee [8];
    logic          lg_oe [8];
    logic          lg_ew [8];
    logic          lg_ow [8];
    logic [AW-2:0] lg_er [8];
    logic [AW-2:0] lg_or [8];
    logic          lg_busy_ok;

    // {write, word, addr, wdata, expected rd_data at done}
    localparam logic [41:0] VEC [16] = '{
        {1'b1, 1'b1, 8'h10, 16'h2023, 16'h0000},
        {1'b0, 1'b1, 8'h10, 16'h0000, 16'h2023},
        {1'b0, 1'b0, 8'h10, 16'h0000, 16'h0023},
        {1'b0, 1'b0, 8'h11, 16'h0000, 16'h0020},
        {1'b1, 1'b0, 8'h20, 16'hAB5C, 16'h0000},
        {1'b1, 1'b0, 8'h21, 16'h7EFF, 16'h0000},
        {1'b0, 1'b1, 8'h20, 16'h0000, 16'h7E5C},
        {1'b1, 1'b1, 8'h31, 16'hBEEF, 16'h0000},
        {1'b0, 1'b0, 8'h31, 16'h0000, 16'h00EF},
        {1'b0, 1'b0, 8'h32, 16'h0000, 16'h00BE},
        {1'b0, 1'b1, 8'h31, 16'h0000, 16'hBEEF},
        {1'b1, 1'b0, 8'h30, 16'h0011, 16'h0000},
        {1'b0, 1'b1, 8'h30, 16'h0000, 16'hEF11},
        {1'b1, 1'b1, 8'hFF, 16'h1234, 16'h0000},
        {1'b0, 1'b0, 8'h00, 16'h0000, 16'h0012},
        {1'b0, 1'b1, 8'hFF, 16'h0000, 16'h1234}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic wr, input logic wd, input logic [AW-1:0] a,
                          input logic [15:0] wdat, output logic [15:0] rd,
                          output int ncyc);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd;
        req_addr = a; req_wdata = wdat;
        @(negedge clk);
        req_valid = 1'b0;
        lg_busy_ok = 1'b1;
        n = 0;
        forever begin
            lg_ee[n] = bank_even_en; lg_oe[n] = bank_odd_en;
            lg_ew[n] = bank_even_we; lg_ow[n] = bank_odd_we;
            lg_er[n] = bank_even_row; lg_or[n] = bank_odd_row;
            if (!busy) lg_busy_ok = 1'b0;
            n++;
            if (done || n == 8) break;
            @(negedge clk);
        end
        rd = rd_data;
        ncyc = n;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int          nc;

        repeat (3) @(negedge clk);
        // R1 / R11: reset state
        chk(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
        chk(!(bank_even_en || bank_odd_en || bank_even_we || bank_odd_we),
            "R1 bank strobes in reset",
            {bank_even_en, bank_odd_en, bank_even_we, bank_odd_we}, 0);
        chk(rd_data == 16'h0, "R11 rd_data in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reset release", {busy, done}, 0);

        // Vector table: R4 R5 R6 R7 R8 R10 R11 data paths
        for (int i = 0; i < 16; i++) begin
            logic        v_wr, v_wd;
            logic [7:0]  v_a;
            logic [15:0] v_wdat, v_exp;
            {v_wr, v_wd, v_a, v_wdat, v_exp} = VEC[i];
            run_op(v_wr, v_wd, v_a, v_wdat, rd, nc);
            chk(rd == v_exp, $sformatf("R5 vector %0d rd_data", i), rd, v_exp);
            chk(nc == ((v_wd && v_a[0]) ? 3 : 2),
                $sformatf("R2 vector %0d cycles to done", i), nc,
                (v_wd && v_a[0]) ? 3 : 2);
            chk(lg_busy_ok, $sformatf("R2 vector %0d busy through access", i),
                lg_busy_ok, 1);
        end

        // R4 / R9: aligned word write, one cycle, both lanes written
        run_op(1'b1, 1'b1, 8'h44, 16'hC0DE, rd, nc);
        chk(lg_ee[0] && lg_oe[0] && lg_ew[0] && lg_ow[0], "R4 aligned write both banks",
            {lg_ee[0], lg_oe[0], lg_ew[0], lg_ow[0]}, 4'hF);
        chk(lg_er[0] == 7'h22 && lg_or[0] == 7'h22, "R4 aligned rows",
            {lg_er[0], lg_or[0]}, {7'h22, 7'h22});
        chk(nc == 2, "R4 aligned done cycle", nc, 2);
        @(negedge clk);
        chk(!busy && !done, "R2 idle after done", {busy, done}, 0);

        // R9: aligned read asserts no write enable
        run_op(1'b0, 1'b1, 8'h44, 16'h0, rd, nc);
        chk(lg_ee[0] && lg_oe[0] && !lg_ew[0] && !lg_ow[0], "R9 read no write enable",
            {lg_ee[0], lg_oe[0], lg_ew[0], lg_ow[0]}, 4'hC);
        chk(rd == 16'hC0DE, "R5 aligned word readback", rd, 16'hC0DE);

        // R6: even byte write touches only the even bank
        run_op(1'b1, 1'b0, 8'h46, 16'h9988, rd, nc);
        chk(lg_ee[0] && !lg_oe[0] && lg_ew[0] && !lg_ow[0], "R6 even byte lanes",
            {lg_ee[0], lg_oe[0], lg_ew[0], lg_ow[0]}, 4'hA);
        chk(lg_er[0] == 7'h23, "R6 even byte row", lg_er[0], 7'h23);

        // R7: odd byte write touches only the odd bank
        run_op(1'b1, 1'b0, 8'h47, 16'h6655, rd, nc);
        chk(!lg_ee[0] && lg_oe[0] && !lg_ew[0] && lg_ow[0], "R7 odd byte lanes",
            {lg_ee[0], lg_oe[0], lg_ew[0], lg_ow[0]}, 4'h5);
        run_op(1'b0, 1'b1, 8'h46, 16'h0, rd, nc);
        chk(rd == 16'h6688, "R7 byte lanes readback as word", rd, 16'h6688);

        // R8: split word write, odd bank first then next even row
        run_op(1'b1, 1'b1, 8'h51, 16'h0F0E, rd, nc);
        chk(!lg_ee[0] && lg_oe[0] && lg_ow[0] && lg_or[0] == 7'h28,
            "R8 split first cycle odd row 0x28",
            {lg_ee[0], lg_oe[0], lg_ow[0], 1'b0, lg_or[0]}, {4'b0110, 7'h28});
        chk(lg_ee[1] && !lg_oe[1] && lg_ew[1] && lg_er[1] == 7'h29,
            "R8 split second cycle even row 0x29",
            {lg_ee[1], lg_oe[1], lg_ew[1], 1'b0, lg_er[1]}, {4'b1010, 7'h29});
        chk(nc == 3, "R8 split done cycle", nc, 3);
        chk(rd == 16'h0, "R11 rd_data zero on write done", rd, 0);

        // R10: split word at the top address wraps to even row 0
        run_op(1'b0, 1'b1, 8'hFF, 16'h0, rd, nc);
        chk(lg_or[0] == 7'h7F && lg_er[1] == 7'h00, "R10 wrap rows",
            {lg_or[0], lg_er[1]}, {7'h7F, 7'h00});
        chk(rd == 16'h1234, "R10 wrap readback", rd, 16'h1234);

        // R3: a request during busy is dropped
        run_op(1'b1, 1'b1, 8'h60, 16'h1111, rd, nc);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_word = 1'b1;
        req_addr = 8'h70; req_wdata = 16'hAAAA;
        @(negedge clk);
        chk(busy, "R2 busy after accept", busy, 1);
        req_addr = 8'h60; req_wdata = 16'hFFFF;   // still valid, but busy
        @(negedge clk);
        req_valid = 1'b0;
        chk(done, "R4 done in second cycle", done, 1);
        @(negedge clk);
        chk(!busy, "R3 dropped request not started", busy, 0);
        run_op(1'b0, 1'b1, 8'h60, 16'h0, rd, nc);
        chk(rd == 16'h1111, "R3 memory unchanged by dropped write", rd, 16'h1111);
        run_op(1'b0, 1'b1, 8'h70, 16'h0, rd, nc);
        chk(rd == 16'hAAAA, "R3 accepted write landed", rd, 16'hAAAA);
        @(negedge clk);
        chk(rd_data == 16'h0, "R11 rd_data zero when idle", rd_data, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule